// File: doc/BRIEF.md
# Last-Writer-Steered Multiport Memory

This block is a memory with several write ports and several read ports, all usable in every clock cycle without stalls. Storage is split into one bank per write port. Each bank holds one copy of simple RAM for each read port, and every copy in a bank receives the same write. A bank is written only by its own port.

A narrow flip-flop table covers the full address range. Each entry records which write port last stored a value at that address. When a read arrives, the table lookup picks the bank that holds the live value. The read data from that bank is returned through a multiplexer.

The bulk of the data sits in plain one-write/one-read RAMs. Only a few index bits per address need multiported flip-flops.

Top module: `lvt_mpram`

## Requirements
- R1: Writes from all write ports in the same cycle to distinct addresses are all stored, with no stall.
- R2: Read data appears on `rd_data` exactly one clock after the read address is presented.
- R3: A read returns the value of the most recent write to that address, whichever write port performed it.
- R4: When two or more write ports target the same address in one cycle, the highest-numbered port's data is the value stored for later reads.
- R5: A read of an address that is being written in the same cycle returns the value held before that write.
- R6: Reset sets every table entry to port index 0. After reset, an address returns the last value written to it through port 0, even if another port wrote it later.
- R7: Each read port works independently. Different read ports may read different addresses in the same cycle.
- R8: A write port whose enable bit is low leaves memory contents unchanged, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the last-writer table |
| wr_en | input | NUM_WR | Write enable, bit p for write port p |
| wr_addr | input | NUM_WR*ADDR_W | Write addresses, port p in bits [p*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_WR*WIDTH | Write data, port p in bits [p*WIDTH +: WIDTH] |
| rd_addr | input | NUM_RD*ADDR_W | Read addresses, port r in bits [r*ADDR_W +: ADDR_W] |
| rd_data | output | NUM_RD*WIDTH | Registered read data, port r in bits [r*WIDTH +: WIDTH] |

## Verification
The hardest case to reach is a read whose answer depends on the table rather than on any single bank. Examples are an address whose live copy moved between banks, a same-cycle collision of several writers, and a reset that rolls the table back while stale data still sits in the higher banks.

The stimulus writes one address through port 0 and then through a higher port, and reads it back. It then pulses reset and reads the same address again, expecting the port-0 value to return. Collisions are produced by driving all write ports at one address in the same cycle, alongside a read of that address.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
    // Width of a write-port index; never below one bit.
    function automatic int idx_bits(input int ports);
        return (ports < 2) ? 1 : $clog2(ports);
    endfunction
endpackage

// File: rtl/lvt_sdp_ram.sv
module lvt_sdp_ram #(
    parameter int DEPTH  = 32,
    parameter int WIDTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = mem[raddr];
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/lvt_bank.sv
module lvt_bank #(
    parameter int NUM_RD = 2,
    parameter int DEPTH  = 32,
    parameter int WIDTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [NUM_RD*ADDR_W-1:0] raddr,
    output logic [NUM_RD*WIDTH-1:0]  rdata
);
    for (genvar r = 0; r < NUM_RD; r++) begin : g_copy
        lvt_sdp_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
            .clk   (clk),
            .we    (we),
            .waddr (waddr),
            .wdata (wdata),
            .raddr (raddr[r*ADDR_W +: ADDR_W]),
            .rdata (rdata[r*WIDTH +: WIDTH])
        );
    end
endmodule

// File: rtl/lvt_table.sv
module lvt_table #(
    parameter int NUM_WR = 3,
    parameter int NUM_RD = 2,
    parameter int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int IDX_W  = lvt_pkg::idx_bits(NUM_WR)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_WR-1:0]        wr_en,
    input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
    input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
    output logic [NUM_RD*IDX_W-1:0]  rd_idx
);
    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0]  ent;
        logic [NUM_RD-1:0][IDX_W-1:0] sel;
    } tbl_t;

    tbl_t st_d, st_q;
    logic [ADDR_W-1:0] wa [NUM_WR];
    logic [ADDR_W-1:0] ra [NUM_RD];

    for (genvar p = 0; p < NUM_WR; p++) begin : g_wa
        assign wa[p] = wr_addr[p*ADDR_W +: ADDR_W];
    end
    for (genvar r = 0; r < NUM_RD; r++) begin : g_ra
        assign ra[r] = rd_addr[r*ADDR_W +: ADDR_W];
        assign rd_idx[r*IDX_W +: IDX_W] = st_q.sel[r];
    end

    always_comb begin
        st_d = st_q;
        // Lookups see the entries before this cycle's writes.
        for (int r = 0; r < NUM_RD; r++) st_d.sel[r] = st_q.ent[ra[r]];
        // Ascending order: the highest-numbered writer lands last.
        for (int p = 0; p < NUM_WR; p++) begin
            if (wr_en[p]) st_d.ent[wa[p]] = IDX_W'(p);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ent <= '0;
            st_q.sel <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Checking helpers: is a higher port writing the same address?
    logic [NUM_WR-1:0] higher_hit;
    always_comb begin
        for (int p = 0; p < NUM_WR; p++) begin
            higher_hit[p] = 1'b0;
            for (int q = p + 1; q < NUM_WR; q++) begin
                if (wr_en[q] && wa[q] == wa[p]) higher_hit[p] = 1'b1;
            end
        end
    end

    // R6
    lvt_reset_chk: assert property (@(posedge clk) rst |=> (st_q.ent == '0));

    for (genvar p = 0; p < NUM_WR; p++) begin : g_chk
        // R4
        lvt_update_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en[p] && !higher_hit[p]) |=> (st_q.ent[$past(wa[p])] == IDX_W'(p)));
    end
endmodule

// File: rtl/lvt_mpram.sv
module lvt_mpram #(
    parameter int NUM_WR = 3,
    parameter int NUM_RD = 2,
    parameter int DEPTH  = 32,
    parameter int WIDTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_WR-1:0]        wr_en,
    input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
    input  logic [NUM_WR*WIDTH-1:0]  wr_data,
    input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
    output logic [NUM_RD*WIDTH-1:0]  rd_data
);
    localparam int IDX_W = lvt_pkg::idx_bits(NUM_WR);

    logic [NUM_RD*WIDTH-1:0] bank_rd [NUM_WR];
    logic [NUM_RD*IDX_W-1:0] sel_idx;

    for (genvar p = 0; p < NUM_WR; p++) begin : g_bank
        lvt_bank #(.NUM_RD(NUM_RD), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
            .clk   (clk),
            .we    (wr_en[p]),
            .waddr (wr_addr[p*ADDR_W +: ADDR_W]),
            .wdata (wr_data[p*WIDTH +: WIDTH]),
            .raddr (rd_addr),
            .rdata (bank_rd[p])
        );
    end

    lvt_table #(.NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .DEPTH(DEPTH)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .rd_idx  (sel_idx)
    );

    always_comb begin
        for (int r = 0; r < NUM_RD; r++) begin
            rd_data[r*WIDTH +: WIDTH] = '0;
            for (int p = 0; p < NUM_WR; p++) begin
                if (sel_idx[r*IDX_W +: IDX_W] == IDX_W'(p))
                    rd_data[r*WIDTH +: WIDTH] = bank_rd[p][r*WIDTH +: WIDTH];
            end
        end
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rchk
        // R2
        lvt_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && wr_en == '0 && $past(wr_en) == '0 &&
             rd_addr[r*ADDR_W +: ADDR_W] == $past(rd_addr[r*ADDR_W +: ADDR_W]))
            |=> $stable(rd_data[r*WIDTH +: WIDTH]));
    end

    // R3
    lvt_top_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en[NUM_WR-1] ##1
        (rd_addr[ADDR_W-1:0] == $past(wr_addr[(NUM_WR-1)*ADDR_W +: ADDR_W]))
        |=> (rd_data[WIDTH-1:0] == $past(wr_data[(NUM_WR-1)*WIDTH +: WIDTH], 2)));
endmodule

// File: tb/lvt_mpram_bench.sv
module lvt_mpram_bench;
    localparam int M  = 3;
    localparam int N  = 2;
    localparam int D  = 32;
    localparam int W  = 16;
    localparam int AW = $clog2(D);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [M-1:0]    wr_en = '0;
    logic [M*AW-1:0] wr_addr = '0;
    logic [M*W-1:0]  wr_data = '0;
    logic [N*AW-1:0] rd_addr = '0;
    logic [N*W-1:0]  rd_data;

    lvt_mpram #(.NUM_WR(M), .NUM_RD(N), .DEPTH(D), .WIDTH(W)) u_lvt_mpram (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Model: last value per port per address, and last writer per address.
    logic [W-1:0] pv [M][D];
    bit           known [M][D];
    int           lastp [D];

    // Per-cycle stimulus
    logic [M-1:0] s_en;
    int           s_wa [M];
    logic [W-1:0] s_wd [M];
    int           s_ra [N];
    bit           s_chk [N];

    task automatic clear_stim();
        s_en = '0;
        for (int p = 0; p < M; p++) begin s_wa[p] = 0; s_wd[p] = '0; end
        for (int r = 0; r < N; r++) begin s_ra[r] = 0; s_chk[r] = 1'b0; end
    endtask

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, model writes at posedge, check at next negedge.
    task automatic cycle(string req);
        logic [W-1:0] e [N];
        bit           v [N];
        for (int r = 0; r < N; r++) begin
            v[r] = s_chk[r] && known[lastp[s_ra[r]]][s_ra[r]];
            e[r] = pv[lastp[s_ra[r]]][s_ra[r]];
        end
        wr_en = s_en;
        for (int p = 0; p < M; p++) begin
            wr_addr[p*AW +: AW] = AW'(s_wa[p]);
            wr_data[p*W +: W]   = s_wd[p];
        end
        for (int r = 0; r < N; r++) rd_addr[r*AW +: AW] = AW'(s_ra[r]);
        @(posedge clk);
        for (int p = 0; p < M; p++) begin
            if (s_en[p]) begin
                pv[p][s_wa[p]] = s_wd[p];
                known[p][s_wa[p]] = 1'b1;
                lastp[s_wa[p]] = p;
            end
        end
        @(negedge clk);
        wr_en = '0;
        for (int r = 0; r < N; r++) if (v[r]) check(req, rd_data[r*W +: W], e[r]);
        clear_stim();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < D; a++) lastp[a] = 0;
    endtask

    task automatic t_reset_rollback();
        clear_stim(); s_en[0] = 1'b1; s_wa[0] = 5; s_wd[0] = 16'h1111; cycle("R6");
        clear_stim(); s_en[2] = 1'b1; s_wa[2] = 5; s_wd[2] = 16'h2222; cycle("R6");
        clear_stim(); s_ra[0] = 5; s_chk[0] = 1'b1; cycle("R3");
        clear_stim(); s_ra[0] = 5; cycle("R3");
        check("R3", rd_data[W-1:0], 16'h2222);
        do_reset();
        clear_stim(); s_ra[1] = 5; cycle("R6");
        check("R6", rd_data[W +: W], 16'h1111);
    endtask

    task automatic t_parallel();
        clear_stim();
        for (int p = 0; p < M; p++) begin
            s_en[p] = 1'b1; s_wa[p] = 10 + p; s_wd[p] = W'(16'hA000 + p);
        end
        cycle("R1");
        clear_stim(); s_ra[0] = 10; s_ra[1] = 12; cycle("R7");
        check("R7", rd_data[W-1:0], 16'hA000);
        check("R7", rd_data[W +: W], 16'hA002);
        clear_stim(); s_ra[0] = 11; s_chk[0] = 1'b1; s_ra[1] = 10; s_chk[1] = 1'b1;
        cycle("R1");
    endtask

    task automatic t_collision();
        clear_stim();
        for (int p = 0; p < M; p++) begin
            s_en[p] = 1'b1; s_wa[p] = 20; s_wd[p] = W'(16'hC000 + p);
        end
        cycle("R4");
        clear_stim(); s_ra[0] = 20; s_ra[1] = 20; cycle("R4");
        check("R4", rd_data[W-1:0], 16'hC002);
        check("R4", rd_data[W +: W], 16'hC002);
        clear_stim();
        s_en[0] = 1'b1; s_wa[0] = 21; s_wd[0] = 16'hD000;
        s_en[1] = 1'b1; s_wa[1] = 21; s_wd[1] = 16'hD001;
        cycle("R4");
        clear_stim(); s_ra[1] = 21; cycle("R4");
        check("R4", rd_data[W +: W], 16'hD001);
    endtask

    task automatic t_read_during_write();
        clear_stim(); s_en[0] = 1'b1; s_wa[0] = 25; s_wd[0] = 16'h0E0E; cycle("R5");
        clear_stim(); s_en[1] = 1'b1; s_wa[1] = 25; s_wd[1] = 16'hF0F0; s_ra[0] = 25;
        cycle("R5");
        check("R5", rd_data[W-1:0], 16'h0E0E);
        clear_stim(); s_ra[0] = 25; cycle("R2");
        check("R2", rd_data[W-1:0], 16'hF0F0);
    endtask

    task automatic t_disabled();
        clear_stim(); s_en[2] = 1'b1; s_wa[2] = 28; s_wd[2] = 16'h5A5A; cycle("R8");
        clear_stim(); wr_addr[AW +: AW] = AW'(28);
        s_wa[1] = 28; s_wd[1] = 16'hDEAD; cycle("R8");
        clear_stim(); s_ra[0] = 28; cycle("R8");
        check("R8", rd_data[W-1:0], 16'h5A5A);
    endtask

    task automatic t_sweep();
        for (int a = 0; a < D; a++) begin
            clear_stim(); s_en[a % M] = 1'b1; s_wa[a % M] = a;
            s_wd[a % M] = W'(a * 16'h0107 + 16'h0033); cycle("R3");
        end
        for (int a = 0; a < D; a += 2) begin
            clear_stim(); s_ra[0] = a; s_ra[1] = a + 1;
            s_chk[0] = 1'b1; s_chk[1] = 1'b1; cycle("R3");
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < M; p++)
            for (int a = 0; a < D; a++) begin pv[p][a] = '0; known[p][a] = 1'b0; end
        clear_stim();
        repeat (2) @(negedge clk);
        do_reset();
        t_reset_rollback();
        t_parallel();
        t_collision();
        t_read_during_write();
        t_disabled();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule